// File: doc/BRIEF.md
# Full-Duplex Serial Port with Register Interface

The block is a UART-style asynchronous serial port attached to a small register bus. It has two addresses. The control address holds the framing mode, the receive enable, the ninth transmit and receive bits, and two completion flags. The data address is shared. A write to it queues a character for transmission, and a read from it returns the last character received.

Bit timing comes from outside the block. `tx_tick_i` pulses once per transmit bit period. `rx_tick_i` pulses sixteen times per receive bit period, and the receiver uses it to find the centre of each bit. Transmitter and receiver run independently of each other. The received character sits in a holding register, so software can read it while the next frame is already arriving. Either completion flag raises `irq_o`. A flag stays set until software writes a zero to it.

Top module: `serial_port`

## Requirements
- R1: After reset the control register reads 0x00, `tx_o` is high and `irq_o` is low.
- R2: In modes 00 and 01 (control bits 7:6), a write to the data address (`addr_i`=1) sends a 10-bit frame: start bit 0, then eight data bits LSB first, then stop bit 1. Each bit lasts one `tx_tick_i` period.
- R3: In modes 10 and 11 the frame has 11 bits. Control bit 3 is sent between the last data bit and the stop bit.
- R4: At the end of the stop bit, control bit 1 (transmit done) is set. A data write made while a frame is in progress is ignored, and no second frame follows.
- R5: In modes 00 and 01 a received frame with a valid stop bit sets control bit 0 (receive done). Its byte becomes readable at the data address, and control bit 2 takes the stop bit (1).
- R6: In modes 10 and 11 the ninth received bit is written to control bit 2.
- R7: Both completion flags stay set until a control write (`addr_i`=0) writes 0 to them. `irq_o` is high while either flag is set.
- R8: While control bit 4 (receive enable) is 0, incoming frames change neither the receive-done flag nor the holding register.
- R9: A frame whose stop bit samples as 0 is discarded. The flag stays clear, the holding register keeps its value, and the next good frame is received normally.
- R10: If a frame completes while receive done is still set, the new byte overwrites the holding register and the flag stays set.
- R11: A frame can be transmitted and another received at the same time without either being corrupted.
- R12: A low pulse on `rx_i` that ends before the middle of a start bit does not begin a frame.
- R13: The holding register keeps the previous byte, readable, while the next frame is being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 = control, 1 = data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| tx_tick_i | input | 1 | One pulse per transmit bit |
| rx_tick_i | input | 1 | Sixteen pulses per receive bit |
| rx_i | input | 1 | Serial input |
| tx_o | output | 1 | Serial output, idle high |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets three kinds of error. The first is a bad stop bit: a receiver that skips the check raises the flag and overwrites the held byte. The second is a short low glitch: without a mid-start recheck, the receiver takes it as a frame and reports a 0xFF byte. The third is a data write during an active frame, which a careless transmitter restarts or appends. It also covers overrun while the flag is pending, reading the old byte mid-frame, and the ninth-bit position in both directions, where a shifted marker would misplace every data bit.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int CTRL_RX_DONE = 0;
  localparam int CTRL_TX_DONE = 1;
  localparam int CTRL_RX_BIT9 = 2;
  localparam int CTRL_TX_BIT9 = 3;
  localparam int CTRL_RX_EN   = 4;
  localparam int CTRL_MODE_LO = 6;
  localparam logic ADDR_CTRL  = 1'b0;
  localparam logic ADDR_DATA  = 1'b1;

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_e;
endpackage

// File: rtl/serial_tx.sv
module serial_tx
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              nine_i,
  input  logic              bit9_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tx_o
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sh_q    <= '1;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        TX_IDLE: if (load_i) begin
          state_q <= TX_WAIT;
          sh_q    <= {1'b1, (nine_i ? bit9_i : 1'b1), data_i, 1'b0};
          cnt_q   <= nine_i ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
        end
        // align the start bit to a full tick period
        TX_WAIT: if (tick_i) state_q <= TX_SEND;
        TX_SEND: if (tick_i) begin
          if (cnt_q == CNT_W'(1)) begin
            state_q <= TX_IDLE;
            done_q  <= 1'b1;
          end else begin
            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != TX_IDLE);
  assign done_o = done_q;
  assign tx_o   = (state_q == TX_SEND) ? sh_q[0] : 1'b1;

  assert_done_line_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tx_o && !busy_o));
  assert_busy_write_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_SEND && load_i && !tick_i) |=> $stable(sh_q));
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o
);
  localparam int SH_W  = DATA_W + 3;
  localparam int OSR_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;

  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic              rx_s;
  logic [SH_W-1:0]   sh_q, sh_next, preset;
  logic [OSR_W-1:0]  cnt_q;
  logic              done_q, bit9_q;
  logic [DATA_W-1:0] data_q;

  assign rx_s    = sync_q[1];
  assign sh_next = {rx_s, sh_q[SH_W-1:1]};
  // single zero marker; reaching bit 0 means the frame is complete
  assign preset  = nine_i ? ~(SH_W'(1) << (SH_W - 1)) : ~(SH_W'(1) << (SH_W - 2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      sh_q    <= '1;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      data_q  <= '0;
      bit9_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!rx_s) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
          RX_START: begin
            if (cnt_q == OSR_W'(HALF - 1)) begin
              cnt_q   <= '0;
              sh_q    <= preset;
              state_q <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + OSR_W'(1);
            end
          end
          RX_DATA: begin
            if (cnt_q == OSR_W'(OSR - 1)) begin
              cnt_q <= '0;
              if (!sh_next[0]) begin
                state_q <= RX_IDLE;
                if (sh_next[SH_W-1]) begin
                  done_q <= 1'b1;
                  data_q <= nine_i ? sh_next[DATA_W:1] : sh_next[DATA_W+1:2];
                  bit9_q <= nine_i ? sh_next[DATA_W+1] : sh_next[SH_W-1];
                end
              end else begin
                sh_q <= sh_next;
              end
            end else begin
              cnt_q <= cnt_q + OSR_W'(1);
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign bit9_o = bit9_q;

  assert_rx_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == RX_IDLE && !done_o));
  assert_bad_stop_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && state_q == RX_DATA && cnt_q == OSR_W'(OSR - 1) && !sh_next[0] && !rx_s)
      |=> (!done_o && $stable(data_o)));
endmodule

// File: rtl/serial_port.sv
module serial_port
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_tick_i,
  input  logic              rx_tick_i,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              irq_o
);
  logic [1:0]        mode_q;
  logic              rx_en_q, tx_bit9_q, rx_bit9_q, tx_done_q, rx_done_q;
  logic              ctrl_wr, data_wr, nine;
  logic              tx_busy, tx_done_p, rx_done_p, rx_bit9;
  logic [DATA_W-1:0] rx_data, ctrl_rd;
  logic              unused_wbit;

  assign ctrl_wr     = wr_en_i && (addr_i == ADDR_CTRL);
  assign data_wr     = wr_en_i && (addr_i == ADDR_DATA);
  assign nine        = mode_q[1];
  assign unused_wbit = wdata_i[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= 2'b00;
      rx_en_q   <= 1'b0;
      tx_bit9_q <= 1'b0;
      rx_bit9_q <= 1'b0;
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_q    <= wdata_i[CTRL_MODE_LO+1:CTRL_MODE_LO];
        rx_en_q   <= wdata_i[CTRL_RX_EN];
        tx_bit9_q <= wdata_i[CTRL_TX_BIT9];
      end
      // hardware set wins over a same-cycle software write
      if (tx_done_p)    tx_done_q <= 1'b1;
      else if (ctrl_wr) tx_done_q <= wdata_i[CTRL_TX_DONE];
      if (rx_done_p)    rx_done_q <= 1'b1;
      else if (ctrl_wr) rx_done_q <= wdata_i[CTRL_RX_DONE];
      if (rx_done_p)    rx_bit9_q <= rx_bit9;
      else if (ctrl_wr) rx_bit9_q <= wdata_i[CTRL_RX_BIT9];
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_MODE_LO+1:CTRL_MODE_LO] = mode_q;
    ctrl_rd[CTRL_RX_EN]   = rx_en_q;
    ctrl_rd[CTRL_TX_BIT9] = tx_bit9_q;
    ctrl_rd[CTRL_RX_BIT9] = rx_bit9_q;
    ctrl_rd[CTRL_TX_DONE] = tx_done_q;
    ctrl_rd[CTRL_RX_DONE] = rx_done_q;
  end

  assign rdata_o = (addr_i == ADDR_DATA) ? rx_data : ctrl_rd;
  assign irq_o   = tx_done_q | rx_done_q;

  serial_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tx_tick_i),
    .load_i (data_wr),
    .data_i (wdata_i),
    .nine_i (nine),
    .bit9_i (tx_bit9_q),
    .busy_o (tx_busy),
    .done_o (tx_done_p),
    .tx_o   (tx_o)
  );

  serial_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (rx_tick_i),
    .en_i   (rx_en_q),
    .nine_i (nine),
    .rx_i   (rx_i),
    .done_o (rx_done_p),
    .data_o (rx_data),
    .bit9_o (rx_bit9)
  );

  assert_rx_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_q && !ctrl_wr) |=> rx_done_q);
  assert_tx_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_q && !ctrl_wr) |=> tx_done_q);
  assert_write_starts_tx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !tx_busy) |=> tx_busy);
endmodule

// File: tb/sim_serial_port.sv
module sim_serial_port;
  localparam int BIT_CLKS = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_tick = 1'b0, rx_tick = 1'b0, rx = 1'b1;
  logic       tx, irq;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  serial_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_tick_i(tx_tick),
    .rx_tick_i(rx_tick), .rx_i(rx), .tx_o(tx), .irq_o(irq)
  );

  always #4 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % BIT_CLKS;
      tx_tick = (c == BIT_CLKS - 1);
      rx_tick = (c % 4 == 3);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rx_send(input logic [7:0] d, input bit nine, input bit b9, input bit good_stop);
    @(negedge clk);
    rx = 1'b0; wait_clks(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin rx = d[i]; wait_clks(BIT_CLKS); end
    if (nine) begin rx = b9; wait_clks(BIT_CLKS); end
    if (good_stop) begin rx = 1'b1; wait_clks(BIT_CLKS); end
    else begin rx = 1'b0; wait_clks(48); rx = 1'b1; wait_clks(16); end
    rx = 1'b1; wait_clks(BIT_CLKS);
  endtask

  task automatic tx_capture(input int nbits, output logic [10:0] f);
    int t = 0;
    f = '1;
    while (tx !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    wait_clks(BIT_CLKS / 2);
    for (int i = 0; i < nbits; i++) begin
      f[i] = tx;
      if (i < nbits - 1) wait_clks(BIT_CLKS);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_rd(1'b0, v);
    chk(v == 8'h00, "R1 ctrl", v, 0);
    chk(tx === 1'b1, "R1 tx idle", tx, 1);
    chk(irq === 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_tx8();
    logic [10:0] f; logic [7:0] v;
    bus_wr(1'b0, 8'h00);
    fork
      tx_capture(10, f);
      bus_wr(1'b1, 8'hA5);
    join
    chk(f[9:0] == {1'b1, 8'hA5, 1'b0}, "R2 frame", f[9:0], {1'b1, 8'hA5, 1'b0});
    wait_clks(40);
    bus_rd(1'b0, v);
    chk(v[1] == 1'b1, "R4 tx done", v, 8'h02);
    wait_clks(500);
    bus_rd(1'b0, v);
    chk(v[1] == 1'b1 && irq === 1'b1, "R7 sticky tx flag", v, 8'h02);
    bus_wr(1'b0, 8'h00);
    wait_clks(1);
    chk(irq === 1'b0, "R7 irq cleared", irq, 0);
  endtask

  task automatic t_tx9();
    logic [10:0] f;
    bus_wr(1'b0, 8'h88);
    fork tx_capture(11, f); bus_wr(1'b1, 8'h3C); join
    chk(f == {1'b1, 1'b1, 8'h3C, 1'b0}, "R3 mode10 bit9=1", f, {1'b1, 1'b1, 8'h3C, 1'b0});
    wait_clks(40);
    bus_wr(1'b0, 8'hC0);
    fork tx_capture(11, f); bus_wr(1'b1, 8'h5A); join
    chk(f == {1'b1, 1'b0, 8'h5A, 1'b0}, "R3 mode11 bit9=0", f, {1'b1, 1'b0, 8'h5A, 1'b0});
    wait_clks(40);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_tx_busy();
    logic [10:0] f; bit quiet = 1'b1;
    fork
      tx_capture(10, f);
      begin bus_wr(1'b1, 8'h11); wait_clks(200); bus_wr(1'b1, 8'h22); end
    join
    chk(f[9:0] == {1'b1, 8'h11, 1'b0}, "R4 busy write ignored", f[9:0], {1'b1, 8'h11, 1'b0});
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (tx !== 1'b1) quiet = 1'b0; end
    chk(quiet, "R4 no second frame", quiet, 1);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_rx8();
    logic [7:0] v;
    bus_wr(1'b0, 8'h10);
    rx_send(8'h96, 1'b0, 1'b0, 1'b1);
    bus_rd(1'b0, v);
    chk(v[0] && v[2], "R5 flag and stop in bit2", v, 8'h15);
    chk(irq === 1'b1, "R7 irq on rx", irq, 1);
    bus_rd(1'b1, v);
    chk(v == 8'h96, "R5 data", v, 8'h96);
    bus_wr(1'b0, 8'h10);
  endtask

  task automatic t_rx9();
    logic [7:0] v;
    bus_wr(1'b0, 8'h90);
    rx_send(8'h4B, 1'b1, 1'b0, 1'b1);
    bus_rd(1'b0, v);
    chk(v[0] && !v[2], "R6 bit9=0", v, 8'h91);
    bus_rd(1'b1, v);
    chk(v == 8'h4B, "R6 data", v, 8'h4B);
    bus_wr(1'b0, 8'hD0);
    rx_send(8'hE1, 1'b1, 1'b1, 1'b1);
    bus_rd(1'b0, v);
    chk(v[0] && v[2], "R6 bit9=1", v, 8'hD5);
    bus_rd(1'b1, v);
    chk(v == 8'hE1, "R6 data mode11", v, 8'hE1);
    bus_wr(1'b0, 8'h00);
  endtask

  task automatic t_rx_off();
    logic [7:0] v;
    rx_send(8'h77, 1'b0, 1'b0, 1'b1);
    bus_rd(1'b0, v);
    chk(v[0] == 1'b0, "R8 no flag while disabled", v, 0);
    bus_rd(1'b1, v);
    chk(v == 8'hE1, "R8 holding unchanged", v, 8'hE1);
  endtask

  task automatic t_bad_stop();
    logic [7:0] v;
    bus_wr(1'b0, 8'h10);
    rx_send(8'h3E, 1'b0, 1'b0, 1'b0);
    wait_clks(200);
    bus_rd(1'b0, v);
    chk(v[0] == 1'b0, "R9 bad stop no flag", v, 8'h10);
    bus_rd(1'b1, v);
    chk(v == 8'hE1, "R9 holding kept", v, 8'hE1);
    rx_send(8'h5C, 1'b0, 1'b0, 1'b1);
    bus_rd(1'b1, v);
    chk(v == 8'h5C, "R9 recovers", v, 8'h5C);
  endtask

  task automatic t_overrun();
    logic [7:0] v, mid;
    fork
      rx_send(8'h81, 1'b0, 1'b0, 1'b1);
      begin wait_clks(300); bus_rd(1'b1, mid); end
    join
    chk(mid == 8'h5C, "R13 old byte readable mid-frame", mid, 8'h5C);
    bus_rd(1'b0, v);
    chk(v[0] == 1'b1, "R10 flag stays set", v, 8'h15);
    bus_rd(1'b1, v);
    chk(v == 8'h81, "R10 overwritten", v, 8'h81);
    bus_wr(1'b0, 8'h10);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    @(negedge clk);
    rx = 1'b0; wait_clks(4); rx = 1'b1;
    wait_clks(900);
    bus_rd(1'b0, v);
    chk(v[0] == 1'b0, "R12 glitch ignored", v, 8'h10);
    bus_rd(1'b1, v);
    chk(v == 8'h81, "R12 holding unchanged", v, 8'h81);
  endtask

  task automatic t_duplex();
    logic [10:0] f; logic [7:0] v;
    bus_wr(1'b0, 8'h10);
    fork
      tx_capture(10, f);
      rx_send(8'hC3, 1'b0, 1'b0, 1'b1);
      begin wait_clks(100); bus_wr(1'b1, 8'h6D); end
    join
    chk(f[9:0] == {1'b1, 8'h6D, 1'b0}, "R11 tx frame", f[9:0], {1'b1, 8'h6D, 1'b0});
    wait_clks(100);
    bus_rd(1'b1, v);
    chk(v == 8'hC3, "R11 rx data", v, 8'hC3);
    bus_rd(1'b0, v);
    chk(v[1:0] == 2'b11, "R11 both flags", v, 8'h17);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);
    t_reset();
    t_tx8();
    t_tx9();
    t_tx_busy();
    t_rx8();
    t_rx9();
    t_rx_off();
    t_bad_stop();
    t_overrun();
    t_glitch();
    t_duplex();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule